// File: doc/BRIEF.md
# Memory Access Fault Checker

This block sits beside the load/store path of a processor and checks every access presented to it. Each access is tested for misalignment against a size mask, against a stack window given by a low and a high limit, and for a bus error reported by the memory side. When a fault is found, the block captures the faulting address in a fault address register. It also builds a fault status word that holds a cause code and, for misaligned accesses, the direction, the destination register index and a word-size flag.

The three fault kinds are gated differently. A stack window violation always raises a trap request. A misaligned access always updates the registers, but it traps only when exceptions are enabled. A bus error is ignored while exceptions are disabled. When exceptions are enabled, a bus error captures the address, and it traps only if the configuration bit for the bus in use (instruction fetch or data) is set. Flushing the pipeline and vectoring to a handler are left to the surrounding core.

Top module: `mem_fault_chk`

## Requirements
- R1: While reset is asserted and after it is released, fault address, fault status and trap request are all zero.
- R2: An access is misaligned when (address AND mask) is nonzero. The status word then becomes cause code 1 in bits 4:0, the destination register index in bits 9:5 and the write flag in bit 10. The address is captured.
- R3: For a misaligned access, status bit 11 is set exactly when the mask is all ones (3, a word access).
- R4: A misaligned access updates address and status whether or not exceptions are enabled, but requests a trap only when exc_en_i is 1.
- R5: A stack violation (address unsigned below stack_lo_i or above stack_hi_i; both limits are inside the window) captures the address, sets status to cause code 7 and always requests a trap, even with exc_en_i at 0.
- R6: A bus error with exc_en_i at 0 changes neither address nor status and requests no trap.
- R7: A bus error with exc_en_i at 1 captures the address. If the configuration bit for the selected bus is 1 (ibus_exc_cfg_i when fetch_i is 1, otherwise dbus_exc_cfg_i), status becomes cause 3 (fetch) or 4 (data) and a trap is requested. If that bit is 0, status is kept and no trap is requested.
- R8: When faults coincide, a stack violation takes precedence over a misaligned access, and a misaligned access takes precedence over a bus error.
- R9: Address and status change at the clock edge after the access. The trap request is high for exactly the one cycle after each trapping access. A cycle with acc_valid_i at 0 changes nothing.
- R10: An aligned access that stays inside the stack window and has no bus error leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| addr_i | input | AW (32) | Access address |
| align_mask_i | input | MW (2) | Size mask: 0 byte, 1 halfword, 3 word |
| wr_i | input | 1 | Access is a store |
| rd_idx_i | input | 5 | Destination register index |
| stack_lo_i | input | AW (32) | Lowest legal stack address |
| stack_hi_i | input | AW (32) | Highest legal stack address |
| bus_err_i | input | 1 | Memory side reported an error |
| fetch_i | input | 1 | Error belongs to the instruction bus (1) or data bus (0) |
| exc_en_i | input | 1 | Exceptions enabled |
| ibus_exc_cfg_i | input | 1 | Instruction-bus errors may trap |
| dbus_exc_cfg_i | input | 1 | Data-bus errors may trap |
| fault_addr_o | output | AW (32) | Captured faulting address |
| fault_stat_o | output | SW (32) | Fault status word |
| trap_req_o | output | 1 | One-cycle trap request |

## Verification
Misaligned accesses are tried with a halfword mask and with a word mask, as loads and as stores, and with exceptions on and off. This separates the field packing from the word flag and from the trap gating. Stack probes sit just below the low limit, just above the high limit and exactly on each limit, which shows whether the bound comparisons are inclusive. Bus errors are applied with every combination of enable, bus select and configuration bit, and further cases combine two fault kinds at once to fix the priority order. Idle cycles placed after faulting accesses confirm that the trap request lasts one cycle.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int unsigned CAUSE_W  = 5;
  localparam int unsigned RD_W     = 5;
  localparam int unsigned SYN_W    = 12;
  localparam int unsigned RD_LSB   = 5;
  localparam int unsigned WR_BIT   = 10;
  localparam int unsigned WORD_BIT = 11;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE     = 5'd0,
    CAUSE_MISALIGN = 5'd1,
    CAUSE_IBUS     = 5'd3,
    CAUSE_DBUS     = 5'd4,
    CAUSE_STACK    = 5'd7
  } cause_e;

  typedef struct packed {
    logic             ld_addr;
    logic             ld_stat;
    logic             trap;
    logic [SYN_W-1:0] syn;
  } fault_t;

  // source index is also priority: 0 wins
  localparam int unsigned N_SRC     = 3;
  localparam int unsigned SRC_STACK = 0;
  localparam int unsigned SRC_ALIGN = 1;
  localparam int unsigned SRC_BUS   = 2;
endpackage

// File: rtl/mfc_align_chk.sv
module mfc_align_chk
  import mfc_pkg::*;
#(
  parameter int unsigned MW = 2
) (
  input  logic            valid_i,
  input  logic [MW-1:0]   addr_lo_i,
  input  logic [MW-1:0]   mask_i,
  input  logic            wr_i,
  input  logic [RD_W-1:0] rd_i,
  input  logic            exc_en_i,
  output fault_t          fault_o
);
  logic miss;
  assign miss = valid_i && |(addr_lo_i & mask_i);

  always_comb begin
    fault_o = '0;
    if (miss) begin
      fault_o.ld_addr              = 1'b1;
      fault_o.ld_stat              = 1'b1;
      fault_o.trap                 = exc_en_i;
      fault_o.syn[CAUSE_W-1:0]     = CAUSE_MISALIGN;
      fault_o.syn[RD_LSB +: RD_W]  = rd_i;
      fault_o.syn[WR_BIT]          = wr_i;
      fault_o.syn[WORD_BIT]        = (mask_i == {MW{1'b1}});
    end
  end
endmodule

// File: rtl/mfc_stack_chk.sv
module mfc_stack_chk
  import mfc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output fault_t        fault_o
);
  logic outside;
  assign outside = valid_i && ((addr_i < lo_i) || (addr_i > hi_i));

  always_comb begin
    fault_o = '0;
    if (outside) begin
      fault_o.ld_addr          = 1'b1;
      fault_o.ld_stat          = 1'b1;
      fault_o.trap             = 1'b1;
      fault_o.syn[CAUSE_W-1:0] = CAUSE_STACK;
    end
  end
endmodule

// File: rtl/mfc_bus_chk.sv
module mfc_bus_chk
  import mfc_pkg::*;
(
  input  logic   valid_i,
  input  logic   bus_err_i,
  input  logic   fetch_i,
  input  logic   exc_en_i,
  input  logic   icfg_i,
  input  logic   dcfg_i,
  output fault_t fault_o
);
  logic act, allow;
  assign act   = valid_i && bus_err_i && exc_en_i;
  assign allow = fetch_i ? icfg_i : dcfg_i;

  always_comb begin
    fault_o = '0;
    if (act) begin
      fault_o.ld_addr          = 1'b1;
      fault_o.ld_stat          = allow;
      fault_o.trap             = allow;
      fault_o.syn[CAUSE_W-1:0] = fetch_i ? CAUSE_IBUS : CAUSE_DBUS;
    end
  end
endmodule

// File: rtl/mfc_fault_sel.sv
module mfc_fault_sel
  import mfc_pkg::*;
#(
  parameter int unsigned N = N_SRC
) (
  input  fault_t src_i [N],
  output fault_t sel_o
);
  always_comb begin
    sel_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (src_i[k].ld_addr) sel_o = src_i[k];
    end
  end
endmodule

// File: rtl/mem_fault_chk.sv
module mem_fault_chk
  import mfc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 2,
  parameter int unsigned SW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_valid_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [MW-1:0]   align_mask_i,
  input  logic            wr_i,
  input  logic [RD_W-1:0] rd_idx_i,
  input  logic [AW-1:0]   stack_lo_i,
  input  logic [AW-1:0]   stack_hi_i,
  input  logic            bus_err_i,
  input  logic            fetch_i,
  input  logic            exc_en_i,
  input  logic            ibus_exc_cfg_i,
  input  logic            dbus_exc_cfg_i,
  output logic [AW-1:0]   fault_addr_o,
  output logic [SW-1:0]   fault_stat_o,
  output logic            trap_req_o
);
  localparam int unsigned PAD_W = SW - SYN_W;

  fault_t src [N_SRC];
  fault_t sel;

  mfc_stack_chk #(.AW(AW)) u_stack (
    .valid_i (acc_valid_i),
    .addr_i  (addr_i),
    .lo_i    (stack_lo_i),
    .hi_i    (stack_hi_i),
    .fault_o (src[SRC_STACK])
  );

  mfc_align_chk #(.MW(MW)) u_align (
    .valid_i   (acc_valid_i),
    .addr_lo_i (addr_i[MW-1:0]),
    .mask_i    (align_mask_i),
    .wr_i      (wr_i),
    .rd_i      (rd_idx_i),
    .exc_en_i  (exc_en_i),
    .fault_o   (src[SRC_ALIGN])
  );

  mfc_bus_chk u_bus (
    .valid_i   (acc_valid_i),
    .bus_err_i (bus_err_i),
    .fetch_i   (fetch_i),
    .exc_en_i  (exc_en_i),
    .icfg_i    (ibus_exc_cfg_i),
    .dcfg_i    (dbus_exc_cfg_i),
    .fault_o   (src[SRC_BUS])
  );

  mfc_fault_sel #(.N(N_SRC)) u_sel (
    .src_i (src),
    .sel_o (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_addr_o <= '0;
      fault_stat_o <= '0;
      trap_req_o   <= 1'b0;
    end else begin
      if (sel.ld_addr) fault_addr_o <= addr_i;
      if (sel.ld_stat) fault_stat_o <= {{PAD_W{1'b0}}, sel.syn};
      trap_req_o <= sel.trap;
    end
  end
endmodule

// File: rtl/mem_fault_chk_sva.sv
module mem_fault_chk_sva
  import mfc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 2,
  parameter int unsigned SW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            acc_valid_i,
  input logic [AW-1:0]   addr_i,
  input logic [MW-1:0]   align_mask_i,
  input logic            wr_i,
  input logic [RD_W-1:0] rd_idx_i,
  input logic [AW-1:0]   stack_lo_i,
  input logic [AW-1:0]   stack_hi_i,
  input logic            bus_err_i,
  input logic            fetch_i,
  input logic            exc_en_i,
  input logic            ibus_exc_cfg_i,
  input logic            dbus_exc_cfg_i,
  input logic [AW-1:0]   fault_addr_o,
  input logic [SW-1:0]   fault_stat_o,
  input logic            trap_req_o
);
  logic in_win, mis, bus_ok;
  assign in_win = (addr_i >= stack_lo_i) && (addr_i <= stack_hi_i);
  assign mis    = |(addr_i[MW-1:0] & align_mask_i);
  assign bus_ok = fetch_i ? ibus_exc_cfg_i : dbus_exc_cfg_i;

  // R5
  stack_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !in_win |=> trap_req_o && fault_stat_o[CAUSE_W-1:0] == CAUSE_STACK
                               && fault_addr_o == $past(addr_i));

  // R2
  align_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && in_win && mis |=> fault_stat_o[CAUSE_W-1:0] == CAUSE_MISALIGN
      && fault_stat_o[RD_LSB +: RD_W] == $past(rd_idx_i)
      && fault_stat_o[WR_BIT] == $past(wr_i) && fault_addr_o == $past(addr_i));

  // R3
  word_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && in_win && mis |=> fault_stat_o[WORD_BIT] == ($past(align_mask_i) == {MW{1'b1}}));

  // R4
  align_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && in_win && mis |=> trap_req_o == $past(exc_en_i));

  // R6
  bus_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && in_win && !mis && !exc_en_i |=> !trap_req_o && $stable(fault_addr_o)
                                                  && $stable(fault_stat_o));

  // R7
  bus_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && in_win && !mis && bus_err_i && exc_en_i |=>
      fault_addr_o == $past(addr_i) && trap_req_o == $past(bus_ok));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !trap_req_o && $stable(fault_addr_o) && $stable(fault_stat_o));
endmodule

bind mem_fault_chk mem_fault_chk_sva #(.AW(AW), .MW(MW), .SW(SW)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .addr_i         (addr_i),
  .align_mask_i   (align_mask_i),
  .wr_i           (wr_i),
  .rd_idx_i       (rd_idx_i),
  .stack_lo_i     (stack_lo_i),
  .stack_hi_i     (stack_hi_i),
  .bus_err_i      (bus_err_i),
  .fetch_i        (fetch_i),
  .exc_en_i       (exc_en_i),
  .ibus_exc_cfg_i (ibus_exc_cfg_i),
  .dbus_exc_cfg_i (dbus_exc_cfg_i),
  .fault_addr_o   (fault_addr_o),
  .fault_stat_o   (fault_stat_o),
  .trap_req_o     (trap_req_o)
);

// File: tb/tb_mem_fault_chk.sv
`timescale 1ns/1ps
module tb_mem_fault_chk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  align_mask_i = '0;
  logic        wr_i = 1'b0;
  logic [4:0]  rd_idx_i = '0;
  logic [31:0] stack_lo_i = 32'h1000;
  logic [31:0] stack_hi_i = 32'h1FFF;
  logic        bus_err_i = 1'b0;
  logic        fetch_i = 1'b0;
  logic        exc_en_i = 1'b0;
  logic        ibus_exc_cfg_i = 1'b0;
  logic        dbus_exc_cfg_i = 1'b0;
  logic [31:0] fault_addr_o;
  logic [31:0] fault_stat_o;
  logic        trap_req_o;

  mem_fault_chk dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] stat;
    logic        req;
    int          rq;
  } exp_t;

  exp_t q [$];
  int checks = 0;
  int errors = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_stat = '0;
  bit done = 0;

  // next-access stimulus
  bit        n_v, n_wr, n_be, n_fe, n_en, n_ic, n_dc;
  bit [31:0] n_a;
  bit [1:0]  n_m;
  bit [4:0]  n_rd;

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input int rq);
    exp_t e;
    bit stk, una, bus, cfg;
    logic req;
    @(negedge clk_i);
    acc_valid_i = n_v; addr_i = n_a; align_mask_i = n_m; wr_i = n_wr; rd_idx_i = n_rd;
    bus_err_i = n_be; fetch_i = n_fe; exc_en_i = n_en;
    ibus_exc_cfg_i = n_ic; dbus_exc_cfg_i = n_dc;
    stk = n_v && (n_a < stack_lo_i || n_a > stack_hi_i);
    una = n_v && ((n_a[1:0] & n_m) != 2'b00);
    bus = n_v && n_be && n_en;
    cfg = n_fe ? n_ic : n_dc;
    req = 1'b0;
    if (stk) begin
      m_addr = n_a; m_stat = 32'd7; req = 1'b1;
    end else if (una) begin
      m_addr = n_a;
      m_stat = 32'd1 | (32'(n_rd) << 5) | (32'(n_wr) << 10) | (32'(n_m == 2'd3) << 11);
      req = n_en;
    end else if (bus) begin
      m_addr = n_a;
      if (cfg) begin
        m_stat = n_fe ? 32'd3 : 32'd4; req = 1'b1;
      end
    end
    e.addr = m_addr; e.stat = m_stat; e.req = req; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic set_acc(input bit [31:0] a, input bit [1:0] m, input bit wr,
                         input bit [4:0] rd, input bit en);
    n_v = 1; n_a = a; n_m = m; n_wr = wr; n_rd = rd; n_en = en;
    n_be = 0; n_fe = 0; n_ic = 0; n_dc = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.rq, fault_addr_o, e.addr, "fault_addr");
        chk(e.rq, fault_stat_o, e.stat, "fault_stat");
        chk(e.rq, {31'b0, trap_req_o}, {31'b0, e.req}, "trap_req");
      end
    end
  end

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #13;
    // R1 during reset
    chk(1, fault_addr_o, 32'h0, "reset addr");
    chk(1, fault_stat_o, 32'h0, "reset stat");
    chk(1, {31'b0, trap_req_o}, 32'h0, "reset req");
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    n_v = 0; n_a = 0; n_m = 0; n_wr = 0; n_rd = 0; n_be = 0; n_fe = 0; n_en = 0; n_ic = 0; n_dc = 0;
    step(1);                                   // R1 idle after release
    set_acc(32'h1004, 2'd3, 0, 5'd4, 1); step(10);  // R10 aligned, in window
    set_acc(32'h1001, 2'd1, 0, 5'd5, 1); step(2);   // R2 halfword misaligned load
    set_acc(32'h1002, 2'd3, 1, 5'd31, 1); step(3);  // R3 word misaligned store
    set_acc(32'h1003, 2'd1, 1, 5'd9, 1); step(3);   // R3 halfword: bit 11 clear
    set_acc(32'h1003, 2'd3, 0, 5'd2, 0); step(4);   // R4 disabled: regs update, no trap
    n_v = 0; step(9);                               // R9 idle, pulse ends
    set_acc(32'h0FFC, 2'd0, 0, 5'd0, 0); step(5);   // R5 below low limit, disabled
    set_acc(32'h2000, 2'd0, 1, 5'd0, 1); step(5);   // R5 above high limit
    set_acc(32'h1000, 2'd3, 0, 5'd0, 1); step(5);   // R5 low limit is legal
    set_acc(32'h1FFF, 2'd0, 0, 5'd0, 1); step(5);   // R5 high limit is legal
    set_acc(32'h1010, 2'd3, 0, 5'd1, 0); n_be = 1; n_ic = 1; n_dc = 1; step(6); // R6
    set_acc(32'h1020, 2'd3, 0, 5'd1, 1); n_be = 1; n_fe = 1; n_ic = 1; step(7); // R7 fetch
    set_acc(32'h1024, 2'd3, 0, 5'd1, 1); n_be = 1; n_dc = 1; step(7);           // R7 data
    set_acc(32'h1028, 2'd3, 0, 5'd1, 1); n_be = 1; n_ic = 1; step(7);           // R7 data cfg off
    set_acc(32'h102C, 2'd3, 0, 5'd1, 1); n_be = 1; n_fe = 1; n_dc = 1; step(7); // R7 fetch cfg off
    set_acc(32'h3001, 2'd1, 1, 5'd3, 1); step(8);   // R8 stack beats misalign
    set_acc(32'h1031, 2'd3, 0, 5'd6, 1); n_be = 1; n_dc = 1; step(8); // R8 misalign beats bus
    set_acc(32'h0FF0, 2'd3, 0, 5'd0, 1); n_be = 1; n_fe = 1; n_ic = 1; step(8); // R8 stack beats bus
    set_acc(32'h0100, 2'd0, 0, 5'd0, 1); step(9);   // R9 back-to-back traps
    set_acc(32'h0200, 2'd0, 0, 5'd0, 1); step(9);
    n_v = 0; n_a = 32'h0; n_m = 2'd3; step(9);      // R9 invalid violating access ignored
    n_v = 0; step(9);
    @(negedge clk_i); @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule